// File: doc/BRIEF.md
# Dual-channel high/low count PWM

This peripheral produces two independent pulse-width modulated outputs, channel A and channel B. Software programs each channel with two counts, one for the time the output is high and one for the time it is low, both in prescaled ticks. Each channel picks one of four incoming source tick enables, divides it by a 7-bit value plus one, and walks through its high and low phases with those prescaled ticks.

Configuration goes through a small 32-bit word-addressed register interface. Each channel has its own duty word. A single control word is shared by the two channels and holds each channel's divider, clock enable, source select, delta-sigma enable and output enable. New duty values take effect only at a period boundary, so a waveform is never cut short in the middle of a phase. Delta-sigma operation is not implemented: setting that bit forces the channel low.

Top module: `pwm_pair`

## Requirements
- R1: Byte address = word index × 4 (addr[4:2] is the index, addr[1:0] is ignored). Index 0 is the channel A duty word and index 1 the channel B duty word. Each holds the high count in bits [31:16] and the low count in bits [15:0], and reads back what was written.
- R2: Index 2 is the control word. Channel A uses bit 0 output enable, bit 2 delta-sigma enable, bits [5:4] source select, bits [14:8] divider and bit 15 clock enable. Channel B uses bit 1 output enable, bit 3 delta-sigma enable, bits [7:6] source select, bits [22:16] divider and bit 23 clock enable. Bits [31:24] read as zero.
- R3: After reset every register reads zero and both outputs are low.
- R4: Indexes 3 to 7 read as zero, and writes to them change no register.
- R5: With divider value D, a channel stays high for high×(D+1) selected source ticks and low for low×(D+1) selected source ticks, repeating. This holds up to D = 127.
- R6: Source select code k (0 to 3) makes the channel count pulses of src_tick[k].
- R7: A channel runs only when its output enable and its clock enable are both 1. Otherwise its output is low and its phase restarts from the beginning of the high phase when it is enabled again.
- R8: A high count of 0 keeps the output low. A low count of 0 with a nonzero high count keeps the output high.
- R9: A duty word written during a period takes effect only when the current period ends. The current high and low phases keep their old lengths.
- R10: A set delta-sigma enable forces that channel's output low.
- R11: Changing one channel's control fields while keeping the other channel's fields alters nothing in the other channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_tick | input | 4 | One tick enable per clock source |
| pwm_out | output | 2 | Bit 0 is channel A, bit 1 is channel B |

## Verification
The hardest case to reach from the ports is a duty rewrite that lands in the middle of a running high phase. The bench watches the output at every falling clock edge. It waits for a rising edge on the output, counts three high samples, and then issues the write in the same sampling loop. Without stopping, it measures the rest of that high phase, the low phase that follows and the next high phase, so it can see whether the old lengths were kept and the new ones applied afterwards. The slow sources and the divider value 127 are covered by measuring full phases against products of high count, divider and source spacing.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int NCH    = 2;
  localparam int NREG   = 8;
  localparam int IDX_W  = $clog2(NREG);
  localparam int ADDR_W = IDX_W + 2;
  localparam int CTRL_W = 24;
  localparam int IDX_CTRL = 2;

  typedef struct packed {
    logic             clk_en;
    logic [DIV_W-1:0] div;
    logic [SEL_W-1:0] sel;
    logic             ds_en;
    logic             out_en;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [NCH-1:0][CNT_W-1:0]    hi_o,
  output logic [NCH-1:0][CNT_W-1:0]    lo_o,
  output chan_cfg_t [NCH-1:0]          cfg_o
);
  logic [IDX_W-1:0]                idx;
  logic [NCH-1:0][DATA_W-1:0]      duty_q, duty_d;
  logic [CTRL_W-1:0]               ctrl_q, ctrl_d;

  assign idx = addr[ADDR_W-1:2];

  // next state
  always_comb begin
    duty_d = duty_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      for (int c = 0; c < NCH; c++) begin
        if (idx == IDX_W'(c)) duty_d[c] = wdata;
      end
      if (idx == IDX_W'(IDX_CTRL)) ctrl_d = wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      ctrl_q <= '0;
    end else begin
      duty_q <= duty_d;
      ctrl_q <= ctrl_d;
    end
  end

  // field decode per channel
  for (genvar c = 0; c < NCH; c++) begin : g_field
    localparam int OEN_B = c;
    localparam int DS_B  = NCH + c;
    localparam int SEL_L = 2 * NCH + SEL_W * c;
    localparam int DIV_L = 8 + 8 * c;
    localparam int CEN_B = DIV_L + DIV_W;
    assign hi_o[c]         = duty_q[c][DATA_W-1:CNT_W];
    assign lo_o[c]         = duty_q[c][CNT_W-1:0];
    assign cfg_o[c].out_en = ctrl_q[OEN_B];
    assign cfg_o[c].ds_en  = ctrl_q[DS_B];
    assign cfg_o[c].sel    = ctrl_q[SEL_L +: SEL_W];
    assign cfg_o[c].div    = ctrl_q[DIV_L +: DIV_W];
    assign cfg_o[c].clk_en = ctrl_q[CEN_B];
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (idx == IDX_W'(c)) rdata = duty_q[c];
    end
    if (idx == IDX_W'(IDX_CTRL)) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == IDX_W'(IDX_CTRL)) |=> $stable(ctrl_q)); // R2
  AST_SPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx > IDX_W'(IDX_CTRL)) |=> ($stable(duty_q) && $stable(ctrl_q))); // R4
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
  import pwm_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chan_cfg_t        cfg_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [NSRC-1:0]  src_tick_i,
  output logic             pwm_o
);
  localparam int SUM_W = CNT_W + 1;

  logic             run, tick, ptick, last;
  logic [SUM_W-1:0] sum;
  logic             loaded_q, loaded_d;
  logic [DIV_W-1:0] pre_q, pre_d, div_q, div_d;
  logic [SUM_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hi_q, hi_d, lo_q, lo_d;

  assign run   = cfg_i.out_en & cfg_i.clk_en;
  assign tick  = src_tick_i[cfg_i.sel];
  assign sum   = {1'b0, hi_q} + {1'b0, lo_q};
  assign last  = (sum == '0) || (cnt_q == sum - SUM_W'(1));
  assign ptick = loaded_q & tick & (pre_q == div_q);

  // next state
  always_comb begin
    loaded_d = loaded_q;
    pre_d    = pre_q;
    div_d    = div_q;
    cnt_d    = cnt_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    if (!run) begin
      loaded_d = 1'b0;
      pre_d    = '0;
      div_d    = '0;
      cnt_d    = '0;
      hi_d     = '0;
      lo_d     = '0;
    end else if (!loaded_q) begin
      loaded_d = 1'b1;
      pre_d    = '0;
      div_d    = cfg_i.div;
      cnt_d    = '0;
      hi_d     = hi_i;
      lo_d     = lo_i;
    end else if (tick) begin
      if (ptick) begin
        pre_d = '0;
        if (last) begin
          cnt_d = '0;
          hi_d  = hi_i;
          lo_d  = lo_i;
          div_d = cfg_i.div;
        end else begin
          cnt_d = cnt_q + SUM_W'(1);
        end
      end else begin
        pre_d = pre_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      pre_q    <= '0;
      div_q    <= '0;
      cnt_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      loaded_q <= loaded_d;
      pre_q    <= pre_d;
      div_q    <= div_d;
      cnt_q    <= cnt_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
    end
  end

  assign pwm_o = run & loaded_q & ~cfg_i.ds_en & (cnt_q < {1'b0, hi_q});

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !loaded_q)); // R7
  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && sum != '0) |-> (cnt_q < sum)); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && run && !(ptick && last)) |=> ($stable(hi_q) && $stable(lo_q))); // R9
  AST_HI_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && hi_q == '0) |-> !pwm_o); // R8
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NCH-1:0][CNT_W-1:0] hi, lo;
  chan_cfg_t [NCH-1:0]       cfg;

  pwm_pair_regs u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .hi_o  (hi),
    .lo_o  (lo),
    .cfg_o (cfg)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_pair_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .cfg_i      (cfg[c]),
      .hi_i       (hi[c]),
      .lo_i       (lo[c]),
      .src_tick_i (src_tick),
      .pwm_o      (pwm_out[c])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |=> (pwm_out == '0)); // R3
endmodule

// File: tb/pwm_pair_test.sv
module pwm_pair_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  src_tick;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  localparam int LIM = 4000;

  always #5 clk = ~clk;

  pwm_pair uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_tick(src_tick), .pwm_out(pwm_out)
  );

  // source k pulses once every k+1 clocks
  initial begin
    int ctr [4];
    for (int k = 0; k < 4; k++) ctr[k] = 0;
    src_tick = '0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        src_tick[k] = (ctr[k] == 0);
        ctr[k] = (ctr[k] == k) ? 0 : ctr[k] + 1;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=expired exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(idx * 4); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    addr = 5'(idx * 4 + 1);
    #1 d = rdata;
  endtask

  function automatic logic [31:0] ctl(input int ch, input int dv, input int sel,
                                      input bit cen, input bit oen, input bit ds);
    logic [31:0] v;
    v = '0;
    if (ch == 0) begin
      v[0] = oen; v[2] = ds; v[5:4] = 2'(sel); v[14:8] = 7'(dv); v[15] = cen;
    end else begin
      v[1] = oen; v[3] = ds; v[7:6] = 2'(sel); v[22:16] = 7'(dv); v[23] = cen;
    end
    return v;
  endfunction

  // measure one full high phase and the following low phase
  task automatic measure(input int ch, output int h, output int l);
    int n;
    n = 0;
    @(negedge clk);
    while (pwm_out[ch] == 1'b1 && n < LIM) begin @(negedge clk); n++; end
    while (pwm_out[ch] == 1'b0 && n < LIM) begin @(negedge clk); n++; end
    h = 0;
    while (pwm_out[ch] == 1'b1 && h < LIM) begin h++; @(negedge clk); end
    l = 0;
    while (pwm_out[ch] == 1'b0 && l < LIM) begin l++; @(negedge clk); end
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  // {hi, lo, div, sel}
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {16'd3, 16'd5, 7'd0,   2'd0},
    {16'd7, 16'd2, 7'd2,   2'd0},
    {16'd1, 16'd1, 7'd0,   2'd1},
    {16'd4, 16'd3, 7'd1,   2'd2},
    {16'd2, 16'd6, 7'd3,   2'd3},
    {16'd5, 16'd5, 7'd127, 2'd0}
  };

  initial begin
    logic [31:0] d;
    int h, l, n;
    wr_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3 reset state
    for (int i = 0; i < 3; i++) begin
      rd(i, d); chk("R3 reg reset", d, 0);
    end
    chk("R3 outputs low", pwm_out, 0);

    // R1 duty readback and field position
    wr(0, 32'h1234_5678); rd(0, d); chk("R1 duty A readback", d, 32'h1234_5678);
    wr(1, 32'h0009_000A); rd(1, d); chk("R1 duty B readback", d, 32'h0009_000A);
    // R2 control width
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R2 upper bits zero", d, 32'h00FF_FFFF);
    wr(2, 32'h0); rd(2, d); chk("R2 ctrl cleared", d, 0);

    // R4 spare indexes
    for (int i = 3; i < 8; i++) begin
      wr(i, 32'hDEAD_BEEF); rd(i, d); chk("R4 spare reads zero", d, 0);
    end
    rd(0, d); chk("R4 duty A untouched", d, 32'h1234_5678);
    rd(2, d); chk("R4 ctrl untouched", d, 0);

    // R5/R6 vector table, alternating channels
    for (int i = 0; i < NV; i++) begin
      int ch, vh, vl, vd, vs;
      ch = i % 2;
      vh = int'(VEC[i][40:25]); vl = int'(VEC[i][24:9]);
      vd = int'(VEC[i][8:2]);   vs = int'(VEC[i][1:0]);
      wr(2, 0);
      wr(ch, {16'(vh), 16'(vl)});
      wr(2, ctl(ch, vd, vs, 1, 1, 0));
      measure(ch, h, l);
      chk($sformatf("R5 R6 vec%0d high", i), h, vh * (vd + 1) * (vs + 1));
      chk($sformatf("R5 R6 vec%0d low", i),  l, vl * (vd + 1) * (vs + 1));
    end
    wr(2, 0);

    // R8 zero counts
    wr(0, {16'd0, 16'd5}); wr(2, ctl(0, 0, 0, 1, 1, 0));
    count_high(0, 200, n); chk("R8 high=0 stays low", n, 0);
    wr(2, 0);
    wr(0, {16'd5, 16'd0}); wr(2, ctl(0, 0, 0, 1, 1, 0));
    repeat (3) @(negedge clk);
    count_high(0, 200, n); chk("R8 low=0 stays high", n, 200);
    wr(2, 0);

    // R7 enable gating
    wr(0, {16'd3, 16'd3});
    wr(2, ctl(0, 0, 0, 0, 1, 0));
    count_high(0, 100, n); chk("R7 clock enable off", n, 0);
    wr(2, ctl(0, 0, 0, 1, 0, 0));
    count_high(0, 100, n); chk("R7 output enable off", n, 0);
    wr(2, ctl(0, 0, 0, 1, 1, 0));
    measure(0, h, l); chk("R7 both enables run", h, 3);
    wr(2, 0);
    @(negedge clk); chk("R7 disable drives low", pwm_out[0], 0);
    // restart begins with a full high phase
    wr(0, {16'd6, 16'd2});
    @(negedge clk); wr_en = 1'b1; addr = 5'd8; wdata = ctl(0, 0, 0, 1, 1, 0);
    @(negedge clk); wr_en = 1'b0;
    n = 0;
    @(negedge clk);
    while (pwm_out[0] && n < LIM) begin n++; @(negedge clk); end
    chk("R7 restart high phase", n, 6);
    wr(2, 0);

    // R10 delta-sigma forces low
    wr(2, ctl(0, 0, 0, 1, 1, 1));
    count_high(0, 100, n); chk("R10 ds forces low", n, 0);
    wr(2, 0);

    // R9 duty rewrite mid high phase
    wr(0, {16'd10, 16'd10});
    wr(2, ctl(0, 0, 0, 1, 1, 0));
    n = 0;
    @(negedge clk);
    while (pwm_out[0] == 1'b1 && n < LIM) begin @(negedge clk); n++; end
    while (pwm_out[0] == 1'b0 && n < LIM) begin @(negedge clk); n++; end
    h = 0;
    while (pwm_out[0] == 1'b1 && h < LIM) begin
      h++;
      if (h == 3) begin wr_en = 1'b1; addr = 5'd0; wdata = {16'd4, 16'd4}; end
      if (h == 4) wr_en = 1'b0;
      @(negedge clk);
    end
    chk("R9 current high kept", h, 10);
    l = 0;
    while (pwm_out[0] == 1'b0 && l < LIM) begin l++; @(negedge clk); end
    chk("R9 current low kept", l, 10);
    h = 0;
    while (pwm_out[0] == 1'b1 && h < LIM) begin h++; @(negedge clk); end
    chk("R9 next high new", h, 4);
    wr(2, 0);

    // R11 channel independence
    wr(0, {16'd3, 16'd5});
    wr(1, {16'd2, 16'd2});
    wr(2, ctl(0, 0, 0, 1, 1, 0) | ctl(1, 1, 0, 1, 1, 0));
    measure(0, h, l); chk("R11 A before", h * 1000 + l, 3005);
    wr(2, ctl(0, 0, 0, 1, 1, 0) | ctl(1, 5, 0, 1, 1, 0));
    measure(0, h, l); chk("R11 A after B change", h * 1000 + l, 3005);
    measure(1, h, l); chk("R11 B new divider", h * 1000 + l, 12012);
    wr(2, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule